// File: doc/BRIEF.md
# Memory-Controller Register Bank with Interrupt

This block is the software-visible register file of an external memory controller. It sits behind a simple synchronous bus with 32-bit data and a 12-bit byte address, which gives a 4 KB window. The bank holds global settings, an interrupt enable and status pair that drives one level-sensitive interrupt line, a timeout setting, and the configuration, control and packed status words of a prefetch engine. It also holds a configurable number of identical chip-select groups, each with seven configuration words. Each register keeps only its own writable bits. Writing the soft-reset bit of the system configuration word reloads every default in one cycle.

The bank moves no data. The prefetch engine reports its FIFO level and remaining count on input ports, and hardware events set interrupt status bits. Read data and the error flag are registered. They are valid in the cycle after the bus access is presented. The error flag pulses for one cycle on a bad access width or an unmapped address.

Top module: `mcreg_bank`

## Requirements
- R1: An access whose size code is not 2 (the only word size) pulses `bus_err`, returns 0 on `bus_rd_data` and changes no register.
- R2: Address 0x000 reads 0x20, and addresses 0x014 and 0x054 read 1. Writes to these three addresses change nothing and raise no error.
- R3: The system configuration word at 0x010 keeps bits 0x19 and resets to 0. A write with bit 1 set reloads the default of every other register in the same cycle, and the system word itself takes the written value masked by 0x19.
- R4: The interrupt enable at 0x01C keeps bits 0xF03. The interrupt status at 0x018 is set by `irq_event` bits under the same mask and cleared by writing ones to it. An event wins over a clear of the same bit in the same cycle.
- R5: `irq_out` is high exactly while some bit is set in both the enable and the status register.
- R6: The timeout word at 0x040 keeps bits 0x1FF1 and resets to 0. The global configuration at 0x050 keeps bits 0xF13 and resets to 0xA00.
- R7: Chip-select group n starts at 0x060 + n*0x30, and word k of the group lies at offset 4*k for k = 0..6. A write reaches only the addressed word of the addressed group.
- R8: The group word masks, for k = 0..6, are 0xFFEF3E13, 0x001F1F8F, 0x001F1F8F, 0x1F8F1F8F, 0x0F1F1F1F, 0x00000FCF and 0x00000F7F. The resets are 0 (group 0) or 0x1000 (other groups), then 0x101001, 0x020201, 0x10031003, 0x10F1111, 0, and finally 0xF40 for group 0 and 0xF00 for the others.
- R9: Prefetch configuration 1 at 0x1E0 keeps bits 0x7F8F7FBF and resets to 0x4000. Prefetch configuration 2 at 0x1E4 keeps bits 0x3FFF and resets to 0.
- R10: Prefetch control at 0x1EC keeps bit 0. A write with bit 0 set presets the FIFO level to 0x40 if configuration 1 bit 0 is set, and to 0 otherwise. Without such a write, a cycle with `pf_level_vld` loads `pf_level`. The preset wins when both occur in the same cycle.
- R11: Prefetch status at 0x1F0 reads the FIFO level in bits [30:24] and `pf_count` in bits [13:0]. Bit 16 is set when the level is strictly greater than configuration 1 bits [14:8]. All other bits are 0.
- R12: A misaligned address, a gap inside a group (offsets 0x1C to 0x2C) or any other unmapped address reads 0 and raises `bus_err` for exactly the one cycle that answers that access.
- R13: `bus_rd_data` and `bus_err` update on the clock edge that accepts the access. Writes and idle cycles return 0 data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access size code, 2 = 32-bit word |
| bus_addr | input | 12 | Byte address in the window |
| bus_wdata | input | 32 | Write data |
| bus_rd_data | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle error pulse |
| irq_event | input | 12 | Hardware events that set status bits |
| pf_level_vld | input | 1 | Load `pf_level` into the FIFO level |
| pf_level | input | 7 | FIFO level from the prefetch engine |
| pf_count | input | 14 | Remaining count from the prefetch engine |
| irq_out | output | 1 | Level interrupt |

## Verification
The hardest situations to reach are same-cycle collisions: an event arriving while software clears the same status bit, and a level update arriving with a control-word preset. The bench drives the event or level input together with the colliding write in one bus cycle and then reads the register back. The threshold flag is stepped through the equal and one-above cases by loading the level through the input port. The soft-reset test first leaves nondefault values in every register class, including a pending interrupt.

// File: rtl/mcreg_pkg.sv
package mcreg_pkg;
    localparam int WORD_W   = 32;
    localparam int ADDR_W   = 12;
    localparam int IRQ_W    = 12;
    localparam int LVL_W    = 7;
    localparam int CNT_W    = 14;
    localparam int CS_WORDS = 7;
    localparam int CS_BASE  = 'h060;
    localparam int CS_STRIDE = 'h030;
    localparam logic [1:0] SIZE_WORD = 2'd2;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    localparam addr_t A_REV     = 12'h000;
    localparam addr_t A_SYSCFG  = 12'h010;
    localparam addr_t A_RSTDONE = 12'h014;
    localparam addr_t A_IRQST   = 12'h018;
    localparam addr_t A_IRQEN   = 12'h01C;
    localparam addr_t A_TMO     = 12'h040;
    localparam addr_t A_GCFG    = 12'h050;
    localparam addr_t A_GSTAT   = 12'h054;
    localparam addr_t A_PFC1    = 12'h1E0;
    localparam addr_t A_PFC2    = 12'h1E4;
    localparam addr_t A_PFCTL   = 12'h1EC;
    localparam addr_t A_PFSTAT  = 12'h1F0;

    localparam word_t M_SYSCFG = 32'h0000_0019;
    localparam word_t M_IRQ    = 32'h0000_0F03;
    localparam word_t M_TMO    = 32'h0000_1FF1;
    localparam word_t M_GCFG   = 32'h0000_0F13;
    localparam word_t M_PFC1   = 32'h7F8F_7FBF;
    localparam word_t M_PFC2   = 32'h0000_3FFF;

    localparam word_t D_GCFG   = 32'h0000_0A00;
    localparam word_t D_PFC1   = 32'h0000_4000;
    localparam word_t V_REV    = 32'h0000_0020;
    localparam word_t V_DONE   = 32'h0000_0001;

    localparam logic [LVL_W-1:0] LVL_PRESET = 7'h40;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_REV, SEL_SYSCFG, SEL_RSTDONE, SEL_IRQST, SEL_IRQEN,
        SEL_TMO, SEL_GCFG, SEL_GSTAT, SEL_PFC1, SEL_PFC2, SEL_PFCTL, SEL_PFSTAT
    } reg_sel_e;

    typedef struct packed {
        logic             rsv_top;
        logic [LVL_W-1:0] level;
        logic [6:0]       rsv_mid;
        logic             over;
        logic [1:0]       rsv_low;
        logic [CNT_W-1:0] count;
    } pf_stat_t;

    function automatic reg_sel_e decode_global(addr_t a);
        case (a)
            A_REV:     return SEL_REV;
            A_SYSCFG:  return SEL_SYSCFG;
            A_RSTDONE: return SEL_RSTDONE;
            A_IRQST:   return SEL_IRQST;
            A_IRQEN:   return SEL_IRQEN;
            A_TMO:     return SEL_TMO;
            A_GCFG:    return SEL_GCFG;
            A_GSTAT:   return SEL_GSTAT;
            A_PFC1:    return SEL_PFC1;
            A_PFC2:    return SEL_PFC2;
            A_PFCTL:   return SEL_PFCTL;
            A_PFSTAT:  return SEL_PFSTAT;
            default:   return SEL_NONE;
        endcase
    endfunction

    function automatic word_t cs_mask(int w);
        case (w)
            0:       return 32'hFFEF_3E13;
            1:       return 32'h001F_1F8F;
            2:       return 32'h001F_1F8F;
            3:       return 32'h1F8F_1F8F;
            4:       return 32'h0F1F_1F1F;
            5:       return 32'h0000_0FCF;
            default: return 32'h0000_0F7F;
        endcase
    endfunction

    function automatic word_t cs_reset(int idx, int w);
        case (w)
            0:       return (idx == 0) ? 32'h0 : 32'h0000_1000;
            1:       return 32'h0010_1001;
            2:       return 32'h0002_0201;
            3:       return 32'h1003_1003;
            4:       return 32'h010F_1111;
            5:       return 32'h0;
            default: return (idx == 0) ? 32'h0000_0F40 : 32'h0000_0F00;
        endcase
    endfunction
endpackage

// File: rtl/mcreg_cs_group.sv
module mcreg_cs_group
    import mcreg_pkg::*;
#(
    parameter int CS_IDX = 0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  soft_rst,
    input  logic  wr_en,
    input  addr_t addr,
    input  word_t wdata,
    output logic  hit,
    output word_t rdata
);
    localparam int GRP_FIRST = CS_BASE + CS_IDX * CS_STRIDE;
    localparam int GRP_END   = GRP_FIRST + CS_STRIDE;
    localparam int USED_SPAN = CS_WORDS * 4;
    localparam logic [ADDR_W:0] FIRST_V = GRP_FIRST[ADDR_W:0];
    localparam logic [ADDR_W:0] END_V   = GRP_END[ADDR_W:0];
    localparam logic [ADDR_W:0] SPAN_V  = USED_SPAN[ADDR_W:0];

    logic [ADDR_W:0] addr_x;
    logic [ADDR_W:0] off;
    logic            in_grp;
    logic [2:0]      widx;
    word_t           cfg_w [CS_WORDS];

    assign addr_x = {1'b0, addr};
    assign off    = addr_x - FIRST_V;
    assign in_grp = (addr_x >= FIRST_V) && (addr_x < END_V);
    assign hit    = in_grp && (off[1:0] == 2'b00) && (off < SPAN_V);
    assign widx   = off[4:2];

    generate
        for (genvar w = 0; w < CS_WORDS; w++) begin : g_word
            word_t q;
            always_ff @(posedge clk) begin
                if (rst || soft_rst)
                    q <= cs_reset(CS_IDX, w);
                else if (wr_en && hit && (widx == 3'(w)))
                    q <= wdata & cs_mask(w);
            end
            assign cfg_w[w] = q;
        end
    endgenerate

    always_comb begin
        rdata = '0;
        for (int w = 0; w < CS_WORDS; w++)
            if (hit && (widx == 3'(w)))
                rdata = cfg_w[w];
    end
endmodule

// File: rtl/mcreg_irq.sv
module mcreg_irq
    import mcreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             soft_rst,
    input  logic             en_wr,
    input  logic             st_wr,
    input  logic [IRQ_W-1:0] wdata,
    input  logic [IRQ_W-1:0] event_in,
    output logic [IRQ_W-1:0] en_q,
    output logic [IRQ_W-1:0] st_q,
    output logic             irq_out
);
    localparam logic [IRQ_W-1:0] KEEP = M_IRQ[IRQ_W-1:0];

    logic [IRQ_W-1:0] clr_bits;
    logic [IRQ_W-1:0] set_bits;

    assign clr_bits = st_wr ? wdata : '0;
    assign set_bits = event_in & KEEP;

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            en_q <= '0;
            st_q <= '0;
        end else begin
            if (en_wr)
                en_q <= wdata & KEEP;
            st_q <= (st_q & ~clr_bits) | set_bits;
        end
    end

    assign irq_out = |(en_q & st_q);
endmodule

// File: rtl/mcreg_prefetch.sv
module mcreg_prefetch
    import mcreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             soft_rst,
    input  logic             c1_wr,
    input  logic             c2_wr,
    input  logic             ctl_wr,
    input  word_t            wdata,
    input  logic             lvl_vld,
    input  logic [LVL_W-1:0] lvl_in,
    input  logic [CNT_W-1:0] cnt_in,
    output word_t            cfg1_q,
    output word_t            cfg2_q,
    output logic             ctl_q,
    output logic [LVL_W-1:0] lvl_q,
    output word_t            stat
);
    pf_stat_t st;

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            cfg1_q <= D_PFC1;
            cfg2_q <= '0;
            ctl_q  <= 1'b0;
            lvl_q  <= '0;
        end else begin
            if (c1_wr)
                cfg1_q <= wdata & M_PFC1;
            if (c2_wr)
                cfg2_q <= wdata & M_PFC2;
            if (ctl_wr)
                ctl_q <= wdata[0];
            if (ctl_wr && wdata[0])
                lvl_q <= cfg1_q[0] ? LVL_PRESET : '0;
            else if (lvl_vld)
                lvl_q <= lvl_in;
        end
    end

    always_comb begin
        st         = '0;
        st.level   = lvl_q;
        st.over    = lvl_q > cfg1_q[14:8];
        st.count   = cnt_in;
        stat       = st;
    end
endmodule

// File: rtl/mcreg_bank.sv
module mcreg_bank
    import mcreg_pkg::*;
#(
    parameter int NUM_CS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_valid,
    input  logic             bus_write,
    input  logic [1:0]       bus_size,
    input  logic [11:0]      bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rd_data,
    output logic             bus_err,
    input  logic [11:0]      irq_event,
    input  logic             pf_level_vld,
    input  logic [6:0]       pf_level,
    input  logic [13:0]      pf_count,
    output logic             irq_out
);
    logic     size_ok;
    logic     acc_ok;
    logic     wr_ok;
    reg_sel_e sel;
    logic     soft_rst;
    logic     mapped;
    word_t    rd_mux;

    word_t    sys_q;
    word_t    tmo_q;
    word_t    gcfg_q;

    logic [IRQ_W-1:0] irq_en_q;
    logic [IRQ_W-1:0] irq_st_q;

    word_t            pf_cfg1_q;
    word_t            pf_cfg2_q;
    logic             pf_ctl_q;
    logic [LVL_W-1:0] pf_lvl_q;
    word_t            pf_stat;

    logic [NUM_CS-1:0] cs_hit;
    word_t             cs_rd [NUM_CS];
    word_t             cs_rd_any;

    assign size_ok  = (bus_size == SIZE_WORD);
    assign acc_ok   = bus_valid && size_ok;
    assign wr_ok    = acc_ok && bus_write;
    assign sel      = decode_global(bus_addr);
    assign soft_rst = wr_ok && (sel == SEL_SYSCFG) && bus_wdata[1];
    assign mapped   = (sel != SEL_NONE) || (|cs_hit);

    always_ff @(posedge clk) begin
        if (rst)
            sys_q <= '0;
        else if (wr_ok && (sel == SEL_SYSCFG))
            sys_q <= bus_wdata & M_SYSCFG;
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            tmo_q  <= '0;
            gcfg_q <= D_GCFG;
        end else if (wr_ok) begin
            if (sel == SEL_TMO)
                tmo_q <= bus_wdata & M_TMO;
            if (sel == SEL_GCFG)
                gcfg_q <= bus_wdata & M_GCFG;
        end
    end

    mcreg_irq u_irq (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_rst),
        .en_wr    (wr_ok && (sel == SEL_IRQEN)),
        .st_wr    (wr_ok && (sel == SEL_IRQST)),
        .wdata    (bus_wdata[IRQ_W-1:0]),
        .event_in (irq_event),
        .en_q     (irq_en_q),
        .st_q     (irq_st_q),
        .irq_out  (irq_out)
    );

    mcreg_prefetch u_pf (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_rst),
        .c1_wr    (wr_ok && (sel == SEL_PFC1)),
        .c2_wr    (wr_ok && (sel == SEL_PFC2)),
        .ctl_wr   (wr_ok && (sel == SEL_PFCTL)),
        .wdata    (bus_wdata),
        .lvl_vld  (pf_level_vld),
        .lvl_in   (pf_level),
        .cnt_in   (pf_count),
        .cfg1_q   (pf_cfg1_q),
        .cfg2_q   (pf_cfg2_q),
        .ctl_q    (pf_ctl_q),
        .lvl_q    (pf_lvl_q),
        .stat     (pf_stat)
    );

    generate
        for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
            mcreg_cs_group #(.CS_IDX(g)) u_grp (
                .clk      (clk),
                .rst      (rst),
                .soft_rst (soft_rst),
                .wr_en    (wr_ok),
                .addr     (bus_addr),
                .wdata    (bus_wdata),
                .hit      (cs_hit[g]),
                .rdata    (cs_rd[g])
            );
        end
    endgenerate

    always_comb begin
        cs_rd_any = '0;
        for (int g = 0; g < NUM_CS; g++)
            cs_rd_any = cs_rd_any | cs_rd[g];
    end

    always_comb begin
        case (sel)
            SEL_REV:     rd_mux = V_REV;
            SEL_SYSCFG:  rd_mux = sys_q;
            SEL_RSTDONE: rd_mux = V_DONE;
            SEL_IRQST:   rd_mux = word_t'(irq_st_q);
            SEL_IRQEN:   rd_mux = word_t'(irq_en_q);
            SEL_TMO:     rd_mux = tmo_q;
            SEL_GCFG:    rd_mux = gcfg_q;
            SEL_GSTAT:   rd_mux = V_DONE;
            SEL_PFC1:    rd_mux = pf_cfg1_q;
            SEL_PFC2:    rd_mux = pf_cfg2_q;
            SEL_PFCTL:   rd_mux = word_t'(pf_ctl_q);
            SEL_PFSTAT:  rd_mux = pf_stat;
            default:     rd_mux = cs_rd_any;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rd_data <= '0;
            bus_err     <= 1'b0;
        end else begin
            bus_rd_data <= (acc_ok && !bus_write && mapped) ? rd_mux : '0;
            bus_err     <= bus_valid && (!size_ok || !mapped);
        end
    end
endmodule

// File: rtl/mcreg_chk.sv
module mcreg_chk (
    input logic        clk,
    input logic        rst,
    input logic        bus_valid,
    input logic        bus_write,
    input logic [1:0]  bus_size,
    input logic [11:0] bus_addr,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rd_data,
    input logic        bus_err,
    input logic [11:0] irq_event,
    input logic        irq_out,
    input logic [11:0] irq_en_q,
    input logic [11:0] irq_st_q,
    input logic [31:0] pf_cfg1_q,
    input logic [6:0]  pf_lvl_q,
    input logic [31:0] gcfg_q
);
    logic        word_acc;
    logic        sr_req;
    logic [11:0] ev_kept;

    assign word_acc = bus_valid && (bus_size == 2'd2);
    assign sr_req   = word_acc && bus_write && (bus_addr == 12'h010) && bus_wdata[1];
    assign ev_kept  = irq_event & 12'hF03;

    AST_BADWIDTH_ERR: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && (bus_size != 2'd2)) |=> (bus_err && (bus_rd_data == 32'h0))); // R1

    AST_REV_READ: assert property (@(posedge clk) disable iff (rst)
        (word_acc && !bus_write && (bus_addr == 12'h000)) |=> (bus_rd_data == 32'h20)); // R2

    AST_SOFT_RESET: assert property (@(posedge clk) disable iff (rst)
        sr_req |=> ((gcfg_q == 32'hA00) && (irq_en_q == 12'h0) && (irq_st_q == 12'h0))); // R3

    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (rst)
        ((ev_kept != 12'h0) && !sr_req) |=> ((irq_st_q & $past(ev_kept)) == $past(ev_kept))); // R4

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        (irq_en_q == 12'h0) |-> !irq_out); // R5

    AST_PF_PRESET: assert property (@(posedge clk) disable iff (rst)
        (word_acc && bus_write && (bus_addr == 12'h1EC) && bus_wdata[0])
        |=> (pf_lvl_q == ($past(pf_cfg1_q[0]) ? 7'h40 : 7'h00))); // R10

    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> $past(bus_valid)); // R12
endmodule

bind mcreg_bank mcreg_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .bus_valid   (bus_valid),
    .bus_write   (bus_write),
    .bus_size    (bus_size),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rd_data (bus_rd_data),
    .bus_err     (bus_err),
    .irq_event   (irq_event),
    .irq_out     (irq_out),
    .irq_en_q    (irq_en_q),
    .irq_st_q    (irq_st_q),
    .pf_cfg1_q   (pf_cfg1_q),
    .pf_lvl_q    (pf_lvl_q),
    .gcfg_q      (gcfg_q)
);

// File: tb/mcreg_bank_tb.sv
`timescale 1ns/1ps
module mcreg_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [1:0]  bus_size = 2'd2;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rd_data;
    logic        bus_err;
    logic [11:0] irq_event = '0;
    logic        pf_level_vld = 1'b0;
    logic [6:0]  pf_level = '0;
    logic [13:0] pf_count = 14'h123;
    logic        irq_out;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    mcreg_bank dut_i (
        .clk          (clk),
        .rst          (rst),
        .bus_valid    (bus_valid),
        .bus_write    (bus_write),
        .bus_size     (bus_size),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rd_data  (bus_rd_data),
        .bus_err      (bus_err),
        .irq_event    (irq_event),
        .pf_level_vld (pf_level_vld),
        .pf_level     (pf_level),
        .pf_count     (pf_count),
        .irq_out      (irq_out)
    );

    // Entry layout: [81:78] requirement, [77] write, [76:65] addr, [64:33] wdata, [32:1] expected data, [0] expected error
    localparam int NV = 48;
    localparam logic [81:0] VEC [NV] = '{
        {4'd2,  1'b0, 12'h000, 32'h0, 32'h0000_0020, 1'b0},  // R2 revision
        {4'd2,  1'b0, 12'h014, 32'h0, 32'h0000_0001, 1'b0},  // R2 reset done
        {4'd2,  1'b0, 12'h054, 32'h0, 32'h0000_0001, 1'b0},  // R2 status
        {4'd2,  1'b1, 12'h000, 32'hFFFF_FFFF, 32'h0, 1'b0},  // R2 write ignored, R13 write returns 0
        {4'd2,  1'b0, 12'h000, 32'h0, 32'h0000_0020, 1'b0},  // R2
        {4'd6,  1'b0, 12'h050, 32'h0, 32'h0000_0A00, 1'b0},  // R6 reset
        {4'd6,  1'b1, 12'h050, 32'hFFFF_FFFF, 32'h0, 1'b0},  // R6
        {4'd6,  1'b0, 12'h050, 32'h0, 32'h0000_0F13, 1'b0},  // R6 mask
        {4'd6,  1'b0, 12'h040, 32'h0, 32'h0, 1'b0},          // R6 timeout reset
        {4'd6,  1'b1, 12'h040, 32'hFFFF_FFFF, 32'h0, 1'b0},  // R6
        {4'd6,  1'b0, 12'h040, 32'h0, 32'h0000_1FF1, 1'b0},  // R6 mask
        {4'd3,  1'b1, 12'h010, 32'hFFFF_FFFD, 32'h0, 1'b0},  // R3 no soft reset
        {4'd3,  1'b0, 12'h010, 32'h0, 32'h0000_0019, 1'b0},  // R3 mask
        {4'd6,  1'b0, 12'h050, 32'h0, 32'h0000_0F13, 1'b0},  // R6 kept (R3 bit clear)
        {4'd8,  1'b0, 12'h060, 32'h0, 32'h0, 1'b0},          // R8 group0 word0
        {4'd7,  1'b0, 12'h090, 32'h0, 32'h0000_1000, 1'b0},  // R7 group1 word0
        {4'd8,  1'b0, 12'h078, 32'h0, 32'h0000_0F40, 1'b0},  // R8 group0 word6
        {4'd7,  1'b0, 12'h0A8, 32'h0, 32'h0000_0F00, 1'b0},  // R7 group1 word6
        {4'd8,  1'b0, 12'h064, 32'h0, 32'h0010_1001, 1'b0},  // R8
        {4'd8,  1'b0, 12'h068, 32'h0, 32'h0002_0201, 1'b0},  // R8
        {4'd8,  1'b0, 12'h06C, 32'h0, 32'h1003_1003, 1'b0},  // R8
        {4'd8,  1'b0, 12'h070, 32'h0, 32'h010F_1111, 1'b0},  // R8
        {4'd8,  1'b0, 12'h074, 32'h0, 32'h0, 1'b0},          // R8
        {4'd8,  1'b1, 12'h1B0, 32'hFFFF_FFFF, 32'h0, 1'b0},  // R8 group7 word0
        {4'd8,  1'b0, 12'h1B0, 32'h0, 32'hFFEF_3E13, 1'b0},  // R8
        {4'd8,  1'b1, 12'h1B4, 32'hFFFF_FFFF, 32'h0, 1'b0},  // R8 word1
        {4'd8,  1'b0, 12'h1B4, 32'h0, 32'h001F_1F8F, 1'b0},  // R8
        {4'd8,  1'b1, 12'h1BC, 32'hFFFF_FFFF, 32'h0, 1'b0},  // R8 word3
        {4'd8,  1'b0, 12'h1BC, 32'h0, 32'h1F8F_1F8F, 1'b0},  // R8
        {4'd8,  1'b1, 12'h1C0, 32'hFFFF_FFFF, 32'h0, 1'b0},  // R8 word4
        {4'd8,  1'b0, 12'h1C0, 32'h0, 32'h0F1F_1F1F, 1'b0},  // R8
        {4'd8,  1'b1, 12'h1C4, 32'hFFFF_FFFF, 32'h0, 1'b0},  // R8 word5
        {4'd8,  1'b0, 12'h1C4, 32'h0, 32'h0000_0FCF, 1'b0},  // R8
        {4'd8,  1'b1, 12'h1C8, 32'hFFFF_FFFF, 32'h0, 1'b0},  // R8 word6
        {4'd8,  1'b0, 12'h1C8, 32'h0, 32'h0000_0F7F, 1'b0},  // R8
        {4'd12, 1'b0, 12'h1CC, 32'h0, 32'h0, 1'b1},          // R12 group gap
        {4'd7,  1'b0, 12'h180, 32'h0, 32'h0000_1000, 1'b0},  // R7 group6 untouched
        {4'd9,  1'b0, 12'h1E0, 32'h0, 32'h0000_4000, 1'b0},  // R9 reset
        {4'd9,  1'b1, 12'h1E0, 32'hFFFF_FFFF, 32'h0, 1'b0},  // R9
        {4'd9,  1'b0, 12'h1E0, 32'h0, 32'h7F8F_7FBF, 1'b0},  // R9
        {4'd9,  1'b1, 12'h1E4, 32'hFFFF_FFFF, 32'h0, 1'b0},  // R9
        {4'd9,  1'b0, 12'h1E4, 32'h0, 32'h0000_3FFF, 1'b0},  // R9
        {4'd12, 1'b0, 12'h1F8, 32'h0, 32'h0, 1'b1},          // R12 above map
        {4'd12, 1'b0, 12'h002, 32'h0, 32'h0, 1'b1},          // R12 misaligned
        {4'd12, 1'b1, 12'h044, 32'h1, 32'h0, 1'b1},          // R12 unmapped write
        {4'd4,  1'b1, 12'h01C, 32'hFFFF_FFFF, 32'h0, 1'b0},  // R4 enable
        {4'd4,  1'b0, 12'h01C, 32'h0, 32'h0000_0F03, 1'b0},  // R4 mask
        {4'd6,  1'b1, 12'h050, 32'h0000_0004, 32'h0, 1'b0}   // R6 unkept bit
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive at a falling edge, let one rising edge pass, return at the next falling edge.
    task automatic acc(input logic w, input logic [1:0] sz, input logic [11:0] a, input logic [31:0] d);
        bus_valid = 1'b1;
        bus_write = w;
        bus_size  = sz;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_valid    = 1'b0;
        bus_write    = 1'b0;
        bus_size     = 2'd2;
        irq_event    = '0;
        pf_level_vld = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        acc(1'b0, 2'd2, a, 32'h0);
        chk(tag, bus_rd_data, exp);
        chk({tag, " err"}, 32'(bus_err), 32'h0);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        acc(1'b1, 2'd2, a, d);
    endtask

    task automatic idle();
        @(negedge clk);
        irq_event    = '0;
        pf_level_vld = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R13 / R5: reset state
        chk("R13 reset data", bus_rd_data, 32'h0);
        chk("R13 reset err", 32'(bus_err), 32'h0);
        chk("R5 reset irq", 32'(irq_out), 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [81:0] v;
            v = VEC[i];
            acc(v[77], 2'd2, v[76:65], v[64:33]);
            chk($sformatf("R%0d vec%0d data", v[81:78], i), bus_rd_data, v[32:1]);
            chk($sformatf("R%0d vec%0d err", v[81:78], i), 32'(bus_err), 32'(v[0]));
        end
        rd(12'h050, 32'h0, "R6 gcfg cleared");

        // R1: bad width write leaves state, bad width read returns 0
        acc(1'b1, 2'd1, 12'h050, 32'h0000_0F13);
        chk("R1 write err", 32'(bus_err), 32'h1);
        chk("R1 write data", bus_rd_data, 32'h0);
        idle();
        chk("R12 err one cycle", 32'(bus_err), 32'h0);
        rd(12'h050, 32'h0, "R1 gcfg unchanged");
        acc(1'b0, 2'd3, 12'h000, 32'h0);
        chk("R1 read data", bus_rd_data, 32'h0);
        chk("R1 read err", 32'(bus_err), 32'h1);

        // R4 / R5: interrupt path, enable currently 0xF03
        chk("R5 no status", 32'(irq_out), 32'h0);
        irq_event = 12'h001;
        idle();
        chk("R5 set", 32'(irq_out), 32'h1);
        rd(12'h018, 32'h001, "R4 event sets");
        irq_event = 12'h004;
        idle();
        rd(12'h018, 32'h001, "R4 unkept event");
        wr(12'h01C, 32'h0000_0002);
        chk("R5 not enabled", 32'(irq_out), 32'h0);
        wr(12'h018, 32'h0000_0001);
        rd(12'h018, 32'h0, "R4 write one clears");
        irq_event = 12'h100;
        wr(12'h018, 32'h0000_0100);
        rd(12'h018, 32'h100, "R4 event wins");
        wr(12'h01C, 32'h0000_0100);
        chk("R5 enabled pending", 32'(irq_out), 32'h1);

        // R10 / R11: prefetch, cfg1 = 0x7F8F7FBF (bit0 set, threshold 0x7F)
        wr(12'h1EC, 32'h1);
        rd(12'h1EC, 32'h1, "R10 control");
        rd(12'h1F0, 32'h4000_0123, "R11 preset 0x40 under threshold");
        wr(12'h1E0, 32'h0000_1000);
        rd(12'h1F0, 32'h4001_0123, "R11 over threshold");
        pf_level = 7'h10; pf_level_vld = 1'b1;
        idle();
        rd(12'h1F0, 32'h1000_0123, "R11 equal threshold");
        pf_level = 7'h11; pf_level_vld = 1'b1;
        idle();
        rd(12'h1F0, 32'h1101_0123, "R11 one above threshold");
        wr(12'h1EC, 32'h1);
        rd(12'h1F0, 32'h0000_0123, "R10 preset zero");
        wr(12'h1EC, 32'h0);
        rd(12'h1EC, 32'h0, "R10 control cleared");
        wr(12'h1E0, 32'h0000_1001);
        pf_level = 7'h05; pf_level_vld = 1'b1;
        wr(12'h1EC, 32'h1);
        rd(12'h1F0, 32'h4001_0123, "R10 preset wins");

        // R3: soft reset with nondefault state everywhere
        wr(12'h040, 32'h0000_0011);
        wr(12'h010, 32'h0000_000B);
        chk("R3 soft reset no err", 32'(bus_err), 32'h0);
        chk("R3 irq dropped", 32'(irq_out), 32'h0);
        rd(12'h010, 32'h09, "R3 sysconfig value");
        rd(12'h050, 32'h0A00, "R3 gcfg default");
        rd(12'h040, 32'h0, "R3 timeout default");
        rd(12'h01C, 32'h0, "R3 enable default");
        rd(12'h018, 32'h0, "R3 status default");
        rd(12'h1B0, 32'h1000, "R3 group7 word0");
        rd(12'h1C8, 32'h0F00, "R3 group7 word6");
        rd(12'h078, 32'h0F40, "R3 group0 word6");
        rd(12'h1E0, 32'h4000, "R3 prefetch cfg1");
        rd(12'h1E4, 32'h0, "R3 prefetch cfg2");
        rd(12'h1EC, 32'h0, "R3 prefetch control");
        rd(12'h1F0, 32'h0000_0123, "R3 prefetch level");

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired R13 actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule